// File: doc/BRIEF.md
# SPI Burst Exchange Engine

This block runs the data phase of an SPI controller. A request to exchange makes it drain the transmit FIFO one byte at a time. Each byte is shifted out on the serial data output, most significant bit first, while one byte is collected from the serial data input. The serial clock runs at half the system clock. Its idle level and sampling edge follow the selected clock-polarity and clock-phase bits.

Two counts shape an exchange. Both are captured when the exchange starts. The burst count is the number of bytes to move, and zero means no limit. The skip count is used only when discard mode is on: it is the number of leading transfers whose received bytes are thrown away. The exchange ends when the burst count runs out or the transmit FIFO runs dry, whichever comes first. At the end the engine pulses a completion output together with a pulse that clears the exchange request.

A received byte that should be stored but meets a full receive FIFO is dropped, and an overflow pulse is raised. Chip-select generation and register decoding belong to the surrounding controller.

The engine has five states:
- `BX_IDLE` waits for a start.
- `BX_FETCH` pops the next transmit byte, or leaves for `BX_FINISH` when the transmit FIFO is empty.
- `BX_SHIFT` spends two system cycles per bit on the serial clock.
- `BX_STORE` delivers, discards or drops the received byte. It then returns to `BX_FETCH`, or moves to `BX_FINISH` when the burst count is used up.
- `BX_FINISH` pulses completion and returns to `BX_IDLE`.

Top module: `spi_burst_xchg`

## Requirements
- R1: After reset and whenever idle, `busy_o`, `tx_pop_o`, `rx_push_o`, `rx_ovf_o`, `done_o` and `xch_clr_o` are low, and `sclk_o` equals `cpol_i`.
- R2: A start seen in idle captures the counts, the mode and the discard bit. `busy_o` is high from the next cycle through the completion cycle. A start while busy has no effect.
- R3: Each transfer pops one transmit byte and drives it MSB first on `mosi_o`. Each bit takes two system cycles of `sclk_o`: the first cycle at the idle level `cpol_i`, the second inverted. One transfer occupies 18 busy cycles.
- R4: With `cpha_i`=0, data changes on the trailing edge and `miso_i` is sampled on the leading edge. With `cpha_i`=1, data changes on the leading edge and is sampled on the trailing edge. Eight samples form one received byte, MSB first.
- R5: With discard on, the first `skip_len_i` transfers push nothing. With discard off, `skip_len_i` has no effect.
- R6: A byte to be stored is pushed with `rx_push_o` when `rx_full_i` is low. Otherwise it is dropped and `rx_ovf_o` pulses for one cycle instead.
- R7: A nonzero burst count N ends the exchange after N transfers, even if transmit data remains. A burst count of zero sets no limit.
- R8: When the transmit FIFO is empty at a fetch, including at the start, the exchange ends with no pop. An exchange ended this way is busy for one cycle more than one ended by the burst count.
- R9: Completion is a single cycle with `done_o` and `xch_clr_o` both high. The engine is idle the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Exchange request |
| burst_len_i | input | CNT_W | Burst count (0 = unlimited) |
| skip_len_i | input | CNT_W | Leading transfers whose received byte is discarded |
| discard_en_i | input | 1 | Enables the skip count |
| cpol_i | input | 1 | Serial clock idle level |
| cpha_i | input | 1 | Serial clock phase |
| tx_empty_i | input | 1 | Transmit FIFO empty |
| tx_data_i | input | DATA_W | Head of transmit FIFO (first-word fall-through) |
| tx_pop_o | output | 1 | Pop the transmit FIFO |
| rx_full_i | input | 1 | Receive FIFO full |
| rx_push_o | output | 1 | Push `rx_data_o` into the receive FIFO |
| rx_data_o | output | DATA_W | Received byte |
| rx_ovf_o | output | 1 | Received byte dropped because the FIFO was full |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| busy_o | output | 1 | Exchange in progress |
| done_o | output | 1 | Transfer-complete pulse |
| xch_clr_o | output | 1 | Clears the exchange request bit |

## Verification
The bench sweeps every combination of FIFO fill, burst count, skip count, discard bit and receive capacity, rotating through all four clock modes, and predicts each outcome arithmetically.

The sweep targets these corner cases:
- A burst count equal to the fill, and a zero count. An off-by-one ending pops a byte too many, or stops before the FIFO drains.
- Starting with an empty FIFO. A wrong design hangs or pops garbage.
- A skip count larger than the burst. A wrong design stores bytes it should discard.
- A full receive FIFO. A wrong design pushes into it, or stays silent instead of pulsing overflow.
- A bit-level model of the SPI device on the other end. It catches sampling on the wrong edge or bit order reversal as corrupted bytes.
- A start pulse in the middle of each burst. A design that re-arms shows up in the busy length or the completion count.

// File: rtl/spi_bx_pkg.sv
package spi_bx_pkg;
    // Exchange sequencer states
    typedef enum logic [2:0] {
        BX_IDLE,
        BX_FETCH,
        BX_SHIFT,
        BX_STORE,
        BX_FINISH
    } bx_state_e;
endpackage

// File: rtl/spi_bx_shifter.sv
// Serial bit engine: two system cycles per bit, MSB first, mode by cpol/cpha.
module spi_bx_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [DATA_W-1:0] load_data_i,
    input  logic              run_i,
    input  logic              cpol_i,
    input  logic              cpha_i,
    input  logic              miso_i,
    output logic              sclk_o,
    output logic              mosi_o,
    output logic              last_o,
    output logic [DATA_W-1:0] rx_byte_o
);
    localparam int HALF_N = 2 * DATA_W;
    localparam int PH_W   = $clog2(HALF_N);

    logic [PH_W-1:0]   ph_q;
    logic [DATA_W-1:0] tx_sh_q;
    logic [DATA_W-1:0] rx_sh_q;
    logic              mosi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q    <= '0;
            tx_sh_q <= '0;
            rx_sh_q <= '0;
            mosi_q  <= 1'b0;
        end else if (load_i) begin
            ph_q <= '0;
            if (cpha_i) begin
                tx_sh_q <= load_data_i;
            end else begin
                // phase 0: first bit must be present before the leading edge
                mosi_q  <= load_data_i[DATA_W-1];
                tx_sh_q <= {load_data_i[DATA_W-2:0], 1'b0};
            end
        end else if (run_i) begin
            ph_q <= ph_q + 1'b1;
            if (!ph_q[0]) begin
                // leading edge happens at the end of this half
                if (cpha_i) begin
                    mosi_q  <= tx_sh_q[DATA_W-1];
                    tx_sh_q <= {tx_sh_q[DATA_W-2:0], 1'b0};
                end else begin
                    rx_sh_q <= {rx_sh_q[DATA_W-2:0], miso_i};
                end
            end else begin
                // trailing edge happens at the end of this half
                if (cpha_i) begin
                    rx_sh_q <= {rx_sh_q[DATA_W-2:0], miso_i};
                end else begin
                    mosi_q  <= tx_sh_q[DATA_W-1];
                    tx_sh_q <= {tx_sh_q[DATA_W-2:0], 1'b0};
                end
            end
        end
    end

    always_comb begin
        sclk_o    = cpol_i ^ (run_i & ph_q[0]);
        mosi_o    = mosi_q;
        last_o    = run_i && (ph_q == PH_W'(HALF_N - 1));
        rx_byte_o = rx_sh_q;
    end

    // R3: the serial clock toggles on every cycle of a running shift
    assert_sclk_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && $past(run_i)) |-> (sclk_o != $past(sclk_o)));

    // R3: data output only moves on a load or a running shift
    assert_mosi_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !load_i) |=> $stable(mosi_o));
endmodule

// File: rtl/spi_bx_counters.sv
// Burst and skip counters captured at start, stepped once per transfer.
module spi_bx_counters #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] burst_i,
    input  logic [CNT_W-1:0] skip_i,
    input  logic             discard_i,
    input  logic             step_i,
    output logic             keep_o,
    output logic             burst_last_o
);
    logic [CNT_W-1:0] bc_q;
    logic [CNT_W-1:0] tc_q;
    logic             lim_q;
    logic             disc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bc_q   <= '0;
            tc_q   <= '0;
            lim_q  <= 1'b0;
            disc_q <= 1'b0;
        end else if (load_i) begin
            bc_q   <= burst_i;
            tc_q   <= skip_i;
            lim_q  <= |burst_i;
            disc_q <= discard_i;
        end else if (step_i) begin
            if (!keep_o) tc_q <= tc_q - 1'b1;
            if (lim_q)   bc_q <= bc_q - 1'b1;
        end
    end

    always_comb begin
        keep_o       = ~(disc_q & (|tc_q));
        burst_last_o = lim_q && (bc_q == CNT_W'(1));
    end

    // R7: a limited burst never steps past zero
    assert_bc_live_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && lim_q) |-> (bc_q != '0));

    // R5: without discard the skip count is left alone
    assert_tc_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !disc_q && !load_i) |=> $stable(tc_q));
endmodule

// File: rtl/spi_burst_xchg.sv
module spi_burst_xchg
    import spi_bx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CNT_W-1:0]  burst_len_i,
    input  logic [CNT_W-1:0]  skip_len_i,
    input  logic              discard_en_i,
    input  logic              cpol_i,
    input  logic              cpha_i,
    input  logic              tx_empty_i,
    input  logic [DATA_W-1:0] tx_data_i,
    output logic              tx_pop_o,
    input  logic              rx_full_i,
    output logic              rx_push_o,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              rx_ovf_o,
    output logic              sclk_o,
    output logic              mosi_o,
    input  logic              miso_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              xch_clr_o
);
    bx_state_e state_q, state_d;
    logic      cpol_q, cpha_q;
    logic      start_acc;
    logic      shift_last, keep_byte, burst_last;
    logic      cpol_eff;
    logic      load_byte, run_shift, step_xfer;

    assign start_acc = (state_q == BX_IDLE) && start_i;
    assign cpol_eff  = (state_q == BX_IDLE) ? cpol_i : cpol_q;

    // State register and mode capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BX_IDLE;
            cpol_q  <= 1'b0;
            cpha_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (start_acc) begin
                cpol_q <= cpol_i;
                cpha_q <= cpha_i;
            end
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BX_IDLE:   if (start_i) state_d = BX_FETCH;
            BX_FETCH:  state_d = tx_empty_i ? BX_FINISH : BX_SHIFT;
            BX_SHIFT:  if (shift_last) state_d = BX_STORE;
            BX_STORE:  state_d = burst_last ? BX_FINISH : BX_FETCH;
            BX_FINISH: state_d = BX_IDLE;
            default:   state_d = BX_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        busy_o    = (state_q != BX_IDLE);
        tx_pop_o  = (state_q == BX_FETCH) && !tx_empty_i;
        load_byte = tx_pop_o;
        run_shift = (state_q == BX_SHIFT);
        step_xfer = (state_q == BX_STORE);
        rx_push_o = step_xfer && keep_byte && !rx_full_i;
        rx_ovf_o  = step_xfer && keep_byte && rx_full_i;
        done_o    = (state_q == BX_FINISH);
        xch_clr_o = (state_q == BX_FINISH);
    end

    spi_bx_shifter #(.DATA_W(DATA_W)) shifter_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load_byte),
        .load_data_i (tx_data_i),
        .run_i       (run_shift),
        .cpol_i      (cpol_eff),
        .cpha_i      (cpha_q),
        .miso_i      (miso_i),
        .sclk_o      (sclk_o),
        .mosi_o      (mosi_o),
        .last_o      (shift_last),
        .rx_byte_o   (rx_data_o)
    );

    spi_bx_counters #(.CNT_W(CNT_W)) counters_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_i       (start_acc),
        .burst_i      (burst_len_i),
        .skip_i       (skip_len_i),
        .discard_i    (discard_en_i),
        .step_i       (step_xfer),
        .keep_o       (keep_byte),
        .burst_last_o (burst_last)
    );

    // R1: idle serial clock sits at the selected polarity
    assert_idle_sclk_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (sclk_o == cpol_i));

    // R2: busy only begins after an accepted start
    assert_start_only_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));

    // R6: never push into a full receive FIFO, never push and drop together
    assert_push_space_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push_o |-> !rx_full_i);
    assert_push_ovf_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_push_o && rx_ovf_o));

    // R8: no pop from an empty transmit FIFO
    assert_pop_nonempty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop_o |-> !tx_empty_i);

    // R9: completion pulse pairs with the clear and is followed by idle
    assert_done_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (xch_clr_o && busy_o));
    assert_idle_after_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);
endmodule

// File: tb/spi_burst_xchg_tb.sv
module spi_burst_xchg_tb_top;
    localparam int DW = 8;
    localparam int CW = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [CW-1:0] burst_len_i = '0;
    logic [CW-1:0] skip_len_i = '0;
    logic          discard_en_i = 1'b0;
    logic          cpol_i = 1'b0;
    logic          cpha_i = 1'b0;
    logic          tx_empty_i;
    logic [DW-1:0] tx_data_i;
    logic          tx_pop_o;
    logic          rx_full_i;
    logic          rx_push_o;
    logic [DW-1:0] rx_data_o;
    logic          rx_ovf_o;
    logic          sclk_o;
    logic          mosi_o;
    logic          miso_i = 1'b0;
    logic          busy_o;
    logic          done_o;
    logic          xch_clr_o;

    always #2.5 clk = ~clk;

    spi_burst_xchg #(.DATA_W(DW), .CNT_W(CW)) dut_i (.*);

    int n_checks = 0;
    int n_fails  = 0;

    function automatic logic [7:0] txb(int k);
        return 8'((k * 29 + 7) & 255);
    endfunction
    function automatic logic [7:0] misob(int k);
        return 8'((k * 53 + 195) & 255);
    endfunction

    // FIFO models (absolute indices, written only here)
    int tx_rd = 0;
    int tx_end = 0;
    int rx_cnt = 0;
    int rx_base = 0;
    int rx_cap = 8;
    assign tx_empty_i = (tx_rd >= tx_end);
    assign tx_data_i  = txb(tx_rd);
    assign rx_full_i  = ((rx_cnt - rx_base) >= rx_cap);
    always @(posedge clk) begin
        if (tx_pop_o)  tx_rd  <= tx_rd + 1;
        if (rx_push_o) rx_cnt <= rx_cnt + 1;
    end

    // Observation counters and SPI device model, sampled at negedge
    int pops = 0, pushes = 0, ovfs = 0, dones = 0, clrs = 0, busy_cyc = 0;
    int bytes_seen = 0, mosi_err = 0, rx_err = 0;
    int sl_k = 0, sl_idx = 0, sl_bits = 0;
    logic [7:0] sl_acc = '0;
    logic prev_sclk = 1'b0;
    logic mode_pol = 1'b0, mode_pha = 1'b0, mode_disc = 1'b0;
    int run_base = 0, run_skip = 0;

    always @(negedge clk) begin
        if (tx_pop_o)  pops++;
        if (rx_ovf_o)  ovfs++;
        if (done_o)    dones++;
        if (xch_clr_o) clrs++;
        if (busy_o)    busy_cyc++;
        if (rx_push_o) begin
            pushes++;
            if (rx_data_o != misob(sl_k)) rx_err++;
            if (mode_disc && (sl_k - run_base) < run_skip) rx_err++;
        end
        if (tx_pop_o) begin
            sl_k = tx_rd;
            sl_bits = 0;
            sl_acc = '0;
            if (!mode_pha) begin
                miso_i = misob(tx_rd)[7];
                sl_idx = 6;
            end else begin
                sl_idx = 7;
            end
        end else if (busy_o && sclk_o != prev_sclk) begin
            if ((sclk_o != mode_pol) != mode_pha) begin
                sl_acc = {sl_acc[6:0], mosi_o};
                sl_bits++;
                if (sl_bits == 8) begin
                    bytes_seen++;
                    if (sl_acc != txb(sl_k)) mosi_err++;
                end
            end else if (sl_idx >= 0) begin
                miso_i = misob(sl_k)[sl_idx];
                sl_idx--;
            end
        end
        prev_sclk = sclk_o;
    end

    task automatic check(bit ok, string req, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    task automatic run_case(int n, int bc, int tc, bit disc, int cap, bit pol, bit pha);
        int p0, u0, o0, d0, c0, b0, s0, me0, re0;
        int t, cand, stored, exp_busy, guard;
        @(negedge clk);
        tx_end = tx_rd + n;
        rx_base = rx_cnt;
        rx_cap = cap;
        burst_len_i = CW'(bc);
        skip_len_i = CW'(tc);
        discard_en_i = disc;
        cpol_i = pol;
        cpha_i = pha;
        mode_pol = pol;
        mode_pha = pha;
        mode_disc = disc;
        run_base = tx_rd;
        run_skip = tc;
        p0 = pops; u0 = pushes; o0 = ovfs; d0 = dones; c0 = clrs; b0 = busy_cyc;
        s0 = bytes_seen; me0 = mosi_err; re0 = rx_err;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        guard = 0;
        while (busy_o && guard < 400) begin
            @(negedge clk);
            guard++;
            if (guard == 3) start_i = 1'b1;   // R2: start while busy is ignored
            if (guard == 4) start_i = 1'b0;
        end
        start_i = 1'b0;
        check(guard < 400, "R9 exchange completes", guard, 0);
        t = (bc == 0 || bc > n) ? n : bc;
        cand = disc ? t - ((tc < t) ? tc : t) : t;
        stored = (cand < cap) ? cand : cap;
        exp_busy = 18 * t + ((bc != 0 && bc <= n) ? 1 : 2);
        check(pops - p0 == t, "R7/R8 transfers popped", pops - p0, t);
        check(dones - d0 == 1 && clrs - c0 == 1, "R9 one done with clear", dones - d0, 1);
        check(busy_cyc - b0 == exp_busy, "R2/R3/R8 busy length", busy_cyc - b0, exp_busy);
        check(pushes - u0 == stored, "R5 bytes stored", pushes - u0, stored);
        check(ovfs - o0 == cand - stored, "R6 overflow pulses", ovfs - o0, cand - stored);
        check(bytes_seen - s0 == t && mosi_err == me0, "R3 serial out bytes", bytes_seen - s0, t);
        check(rx_err == re0, "R4 received bytes", rx_err - re0, 0);
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        cpol_i = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy_o, "R1 busy idle", busy_o, 0);
        check(sclk_o == cpol_i, "R1 sclk idle level", sclk_o, cpol_i);
        check(!tx_pop_o && !rx_push_o && !rx_ovf_o, "R1 no pop/push", tx_pop_o, 0);
        check(!done_o && !xch_clr_o, "R1 no completion", done_o, 0);
        prev_sclk = sclk_o;
        begin
            int idx;
            idx = 0;
            for (int n = 0; n <= 4; n++)
                for (int bc = 0; bc <= 5; bc++)
                    for (int tc = 0; tc <= 2; tc++)
                        for (int d = 0; d <= 1; d++)
                            for (int ci = 0; ci < 3; ci++) begin
                                int cap;
                                cap = (ci == 0) ? 1 : ((ci == 1) ? 3 : 8);
                                run_case(n, bc, tc, d[0], cap, idx[0], idx[1]);
                                idx++;
                            end
        end
        report();
    end
endmodule